// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one reference waveform per channel into a pair of drive signals, a main output and a complementary output, for half-bridge style loads. When both outputs of a channel are switched on, the main output is active while the reference is high and the complementary output is active while it is low. Each output's turn-on is held back by a programmable dead-time, so one output always switches off before the other switches on. A reference pulse no longer than the dead-time never reaches the output it would have driven.

Each output has its own enable and polarity bit. With only one output of a channel enabled, that output follows the reference directly, with no inversion and no dead-time. The disabled output rests at its inactive level. With neither enabled, both rest at their inactive levels. A single dead-time count is shared by all channels. The reference comes from counter and compare logic elsewhere. Break handling and idle-level selection belong to a neighbouring block. All pins are plain level signals sampled every clock. Nothing here is a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `deadband_gen`

## Requirements
- R1: While reset is asserted, and right after it, every output pin equals its polarity bit (inactive) and the internal delay counters are cleared.
- R2: With both outputs of a channel enabled and dead-time D, the main output becomes active D+1 clock edges after the first edge that samples the reference high, provided the reference stays high throughout.
- R3: With both outputs enabled, the complementary output becomes active D+1 edges after the first edge that samples the reference low, provided the reference stays low.
- R4: With both outputs enabled, an output switches to inactive on the first edge that samples the reference at the level that deactivates it.
- R5: With both outputs enabled, a high pulse lasting D or fewer sampled cycles never appears on the main output, and a low pulse lasting D or fewer never appears on the complementary output.
- R6: The main and complementary outputs of a channel are never both at their active levels.
- R7: With only the main output enabled, its active state equals the reference sampled at the previous edge, with no dead-time, and the complementary pin stays inactive.
- R8: With only the complementary output enabled, its active state equals the reference (not inverted) sampled at the previous edge, with no dead-time, and the main pin stays inactive.
- R9: With neither output of a channel enabled, both pins stay inactive.
- R10: Each pin equals its active state XOR its polarity bit (1 = active-low). A polarity change shows on the pin in the same cycle.
- R11: One 8-bit dead-time count applies to every channel. A count of 0 inserts no delay beyond the single register stage.
- R12: The largest count (255) is honoured exactly: the output turns on at the 256th edge. A level held longer than 255 cycles keeps the output active, because the counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | NCH | Reference waveform, one bit per channel |
| dead_cnt_i | input | DT_W | Shared dead-time in clock cycles |
| main_en_i | input | NCH | Main output enable per channel |
| comp_en_i | input | NCH | Complementary output enable per channel |
| main_pol_i | input | NCH | Main output polarity (1 = active-low) |
| comp_pol_i | input | NCH | Complementary output polarity (1 = active-low) |
| main_o | output | NCH | Main output pins |
| comp_o | output | NCH | Complementary output pins |

## Verification
Polarity acts combinationally, so it is checked a moment after it is driven, within the same cycle. Turn-off and the single-output follow modes land one edge after the reference is sampled. In the dual mode, turn-on lands D+1 edges after the first sample of the new level. The bench drives every input on the falling clock edge and samples on the next falling edge, so each table row reads the result of exactly one rising edge. The 255-count test counts falling edges after the reference step and samples at edge 255, where the output must still be off, and at edge 256, where it must be on.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

  typedef enum logic [1:0] {
    ROUTE_OFF  = 2'b00,
    ROUTE_MAIN = 2'b01,
    ROUTE_COMP = 2'b10,
    ROUTE_PAIR = 2'b11
  } route_e;

  function automatic route_e route_of(input logic main_en, input logic comp_en);
    return route_e'({comp_en, main_en});
  endfunction

endpackage

// File: rtl/deadband_route.sv
module deadband_route
  import deadband_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            ref_i,
  input  logic            main_en_i,
  input  logic            comp_en_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            main_want_o,
  output logic            comp_want_o,
  output logic [DT_W-1:0] main_dt_o,
  output logic [DT_W-1:0] comp_dt_o
);

  route_e route;

  always_comb begin
    route       = route_of(main_en_i, comp_en_i);
    main_want_o = 1'b0;
    comp_want_o = 1'b0;
    main_dt_o   = '0;
    comp_dt_o   = '0;
    unique case (route)
      ROUTE_PAIR: begin
        // complementary pair: dead-time on both turn-on edges
        main_want_o = ref_i;
        comp_want_o = ~ref_i;
        main_dt_o   = dead_cnt_i;
        comp_dt_o   = dead_cnt_i;
      end
      ROUTE_MAIN: main_want_o = ref_i;
      ROUTE_COMP: comp_want_o = ref_i;   // single output follows reference, not inverted
      default: ;
    endcase
  end

endmodule

// File: rtl/deadband_delay.sv
module deadband_delay #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            act_o
);

  localparam logic [DT_W-1:0] RUN_MAX = '1;

  logic            want_q;
  logic [DT_W-1:0] run_q;
  logic [DT_W-1:0] run_d;

  // run length of the current requested level, restarted on every change
  always_comb begin
    if (want_i != want_q)      run_d = '0;
    else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
    else                       run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      run_q  <= '0;
      act_o  <= 1'b0;
    end else begin
      want_q <= want_i;
      run_q  <= run_d;
      act_o  <= want_i && (run_d >= dt_i);
    end
  end

endmodule

// File: rtl/deadband_lane.sv
module deadband_lane #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  input  logic            main_en_i,
  input  logic            comp_en_i,
  input  logic            main_pol_i,
  input  logic            comp_pol_i,
  output logic            main_o,
  output logic            comp_o
);

  logic            main_want, comp_want;
  logic [DT_W-1:0] main_dt, comp_dt;
  logic            main_act, comp_act;

  deadband_route #(.DT_W(DT_W)) u_route (
    .ref_i       (ref_i),
    .main_en_i   (main_en_i),
    .comp_en_i   (comp_en_i),
    .dead_cnt_i  (dead_cnt_i),
    .main_want_o (main_want),
    .comp_want_o (comp_want),
    .main_dt_o   (main_dt),
    .comp_dt_o   (comp_dt)
  );

  deadband_delay #(.DT_W(DT_W)) u_main_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (main_want),
    .dt_i   (main_dt),
    .act_o  (main_act)
  );

  deadband_delay #(.DT_W(DT_W)) u_comp_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .want_i (comp_want),
    .dt_i   (comp_dt),
    .act_o  (comp_act)
  );

  // polarity is applied after dead-time insertion
  assign main_o = main_act ^ main_pol_i;
  assign comp_o = comp_act ^ comp_pol_i;

endmodule

// File: rtl/deadband_gen.sv
module deadband_gen #(
  parameter int NCH  = 3,
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ref_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  input  logic [NCH-1:0]  main_en_i,
  input  logic [NCH-1:0]  comp_en_i,
  input  logic [NCH-1:0]  main_pol_i,
  input  logic [NCH-1:0]  comp_pol_i,
  output logic [NCH-1:0]  main_o,
  output logic [NCH-1:0]  comp_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    deadband_lane #(.DT_W(DT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_i      (ref_i[c]),
      .dead_cnt_i (dead_cnt_i),
      .main_en_i  (main_en_i[c]),
      .comp_en_i  (comp_en_i[c]),
      .main_pol_i (main_pol_i[c]),
      .comp_pol_i (comp_pol_i[c]),
      .main_o     (main_o[c]),
      .comp_o     (comp_o[c])
    );
  end

endmodule

// File: rtl/deadband_gen_chk.sv
module deadband_gen_chk #(
  parameter int NCH  = 3,
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  ref_i,
  input logic [DT_W-1:0] dead_cnt_i,
  input logic [NCH-1:0]  main_en_i,
  input logic [NCH-1:0]  comp_en_i,
  input logic [NCH-1:0]  main_pol_i,
  input logic [NCH-1:0]  comp_pol_i,
  input logic [NCH-1:0]  main_o,
  input logic [NCH-1:0]  comp_o
);

  logic [NCH-1:0] m_act, c_act, pair;
  logic           dt_nz;

  assign m_act = main_o ^ main_pol_i;
  assign c_act = comp_o ^ comp_pol_i;
  assign pair  = main_en_i & comp_en_i;
  assign dt_nz = (dead_cnt_i != '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_act[c] && c_act[c]));

    a_r4_main_off: assert property (@(posedge clk) disable iff (!rst_n)
      (pair[c] && !ref_i[c]) |=> !m_act[c]);

    a_r4_comp_off: assert property (@(posedge clk) disable iff (!rst_n)
      (pair[c] && ref_i[c]) |=> !c_act[c]);

    a_r2_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(m_act[c]) && $past(pair[c] && dt_nz) && $past(pair[c], 2))
        |-> ($past(ref_i[c]) && $past(ref_i[c], 2)));

    a_r3_comp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(c_act[c]) && $past(pair[c] && dt_nz) && $past(pair[c], 2))
        |-> (!$past(ref_i[c]) && !$past(ref_i[c], 2)));

    a_r7_main_only: assert property (@(posedge clk) disable iff (!rst_n)
      (main_en_i[c] && !comp_en_i[c]) |=> (m_act[c] == $past(ref_i[c])) && !c_act[c]);

    a_r8_comp_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_en_i[c] && comp_en_i[c]) |=> (c_act[c] == $past(ref_i[c])) && !m_act[c]);

    a_r9_both_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_en_i[c] && !comp_en_i[c]) |=> !m_act[c] && !c_act[c]);
  end

endmodule

bind deadband_gen deadband_gen_chk #(.NCH(NCH), .DT_W(DT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_i      (ref_i),
  .dead_cnt_i (dead_cnt_i),
  .main_en_i  (main_en_i),
  .comp_en_i  (comp_en_i),
  .main_pol_i (main_pol_i),
  .comp_pol_i (comp_pol_i),
  .main_o     (main_o),
  .comp_o     (comp_o)
);

// File: tb/deadband_gen_tb.sv
module deadband_gen_tb;

  localparam int NCH  = 3;
  localparam int DT_W = 8;
  localparam int NROW = 18;

  typedef struct packed {
    logic [7:0] dt;
    logic [2:0] men, cen, mpol, cpol, refv, exp_m, exp_c;
    logic [3:0] req;
  } row_t;

  // columns: dt, main_en, comp_en, main_pol, comp_pol, ref, expected main, expected comp, requirement
  localparam row_t VEC [NROW] = '{
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b101, 3'b000, 3'b000, 4'd2},  // R2 delay running
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b101, 3'b000, 3'b000, 4'd2},  // R2
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b101, 3'b101, 3'b010, 4'd2},  // R2/R3 on at D+1
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b101, 3'b101, 3'b010, 4'd3},  // R3
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b100, 3'b100, 3'b010, 4'd4},  // R4 immediate off
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b101, 3'b100, 3'b010, 4'd5},  // R5 low pulse swallowed
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b101, 3'b100, 3'b010, 4'd5},  // R5
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b100, 3'b100, 3'b010, 4'd5},  // R5 high pulse swallowed
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b100, 3'b100, 3'b010, 4'd3},  // R3
    '{8'd2, 3'b111, 3'b111, 3'b000, 3'b000, 3'b100, 3'b100, 3'b011, 4'd3},  // R3 comp on
    '{8'd0, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111, 4'd11}, // R11 zero delay
    '{8'd0, 3'b111, 3'b111, 3'b000, 3'b000, 3'b111, 3'b111, 3'b000, 4'd11}, // R11
    '{8'd0, 3'b111, 3'b111, 3'b111, 3'b010, 3'b111, 3'b000, 3'b010, 4'd10}, // R10 polarity
    '{8'd5, 3'b111, 3'b000, 3'b000, 3'b000, 3'b010, 3'b010, 3'b000, 4'd7},  // R7 main only
    '{8'd5, 3'b000, 3'b111, 3'b000, 3'b000, 3'b110, 3'b000, 3'b110, 4'd8},  // R8 comp only
    '{8'd5, 3'b000, 3'b000, 3'b001, 3'b100, 3'b111, 3'b001, 3'b100, 4'd9},  // R9 none enabled
    '{8'd1, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 4'd3},  // R3 restart
    '{8'd1, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111, 4'd3}   // R3
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  ref_i = '0;
  logic [DT_W-1:0] dead_cnt_i = '0;
  logic [NCH-1:0]  main_en_i = '0, comp_en_i = '0;
  logic [NCH-1:0]  main_pol_i = '0, comp_pol_i = '0;
  logic [NCH-1:0]  main_o, comp_o;

  int checks = 0;
  int fails = 0;
  int excl_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  deadband_gen #(.NCH(NCH), .DT_W(DT_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_i      (ref_i),
    .dead_cnt_i (dead_cnt_i),
    .main_en_i  (main_en_i),
    .comp_en_i  (comp_en_i),
    .main_pol_i (main_pol_i),
    .comp_pol_i (comp_pol_i),
    .main_o     (main_o),
    .comp_o     (comp_o)
  );

  task automatic chk(input int req, input string what, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // R6 monitor: active levels never coincide
  always @(negedge clk)
    if (rst_n && (((main_o ^ main_pol_i) & (comp_o ^ comp_pol_i)) != '0)) excl_bad++;

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    main_pol_i = 3'b101;
    comp_pol_i = 3'b010;
    repeat (3) @(negedge clk);
    chk(1, "reset main pins", main_o, 3'b101);  // R1
    chk(1, "reset comp pins", comp_o, 3'b010);  // R1
    main_pol_i = '0;
    comp_pol_i = '0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      dead_cnt_i = VEC[i].dt;
      main_en_i  = VEC[i].men;
      comp_en_i  = VEC[i].cen;
      main_pol_i = VEC[i].mpol;
      comp_pol_i = VEC[i].cpol;
      ref_i      = VEC[i].refv;
      @(negedge clk);
      chk(int'(VEC[i].req), $sformatf("row %0d main", i), main_o, VEC[i].exp_m);
      chk(int'(VEC[i].req), $sformatf("row %0d comp", i), comp_o, VEC[i].exp_c);
    end

    // R12: largest count, then saturation on a long level
    dead_cnt_i = 8'd255;
    main_en_i  = '1;
    comp_en_i  = '1;
    main_pol_i = '0;
    comp_pol_i = '0;
    ref_i      = '0;
    repeat (2) @(negedge clk);
    ref_i = '1;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (k == 255) chk(12, "main still off at edge 255", main_o, 3'b000);
      if (k == 256) chk(12, "main on at edge 256", main_o, 3'b111);
      if (k == 300) begin
        chk(12, "main held past saturation", main_o, 3'b111);
        chk(12, "comp off during long high", comp_o, 3'b000);
      end
    end

    // R10: polarity change is visible within the same cycle
    main_pol_i = 3'b011;
    #1;
    chk(10, "same-cycle polarity", main_o, 3'b100);

    // R1: reset in mid-run forces pins back to polarity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(1, "mid-run reset main", main_o, main_pol_i);
    chk(1, "mid-run reset comp", comp_o, comp_pol_i);
    @(negedge clk);
    rst_n = 1'b1;

    checks++;
    if (excl_bad != 0) begin
      fails++;
      $display("FAIL R6 overlap cycles: actual %0d expected 0", excl_bad);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule